// File: doc/BRIEF.md
# Floating-point exception status recorder

This block folds the IEEE exception flags that one floating-point operation reports into the floating-point status word. An execution unit presents the five raised-flag bits together with the status word that was current when the operation issued, and strobes `valid_i`. On the next clock edge the block registers the updated status word. In the same cycle it raises one of two strobes. `trap_o` asks the surrounding control to take an IEEE exception trap. `pc_adv_o` asks it to move the program counter forward (PC takes next-PC, and next-PC increases by 4).

Some raised flags may also be set in the trap-enable field of the status word. In that case the operation traps, and the current-exception field receives exactly one flag: the most urgent of the enabled ones. The accrued field is left alone and the trap-type field is set to "IEEE exception". If no raised flag is enabled, the whole raised vector goes into the current field, it is ORed into the accrued field, and the PC is advanced. All other status bits pass through unchanged.

Flag bit order, used by every field: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact.

Top module: `fpx_status_rec`

## Requirements
- R1: While `rst_ni` is low, `stat_o`, `trap_o` and `pc_adv_o` are all zero. Reset acts asynchronously.
- R2: A `valid_i` with `flags_i & stat_i[27:23]` non-zero gives `trap_o` = 1 one cycle later. Any other `valid_i` gives `trap_o` = 0.
- R3: On a trap, `stat_o[4:0]` holds exactly one bit: the highest-numbered bit of `flags_i & stat_i[27:23]`. Priority runs invalid (4), overflow (3), underflow (2), divide-by-zero (1), inexact (0).
- R4: Without a trap, `stat_o[4:0]` equals `flags_i` and `stat_o[9:5]` equals `stat_i[9:5] | flags_i`.
- R5: On a trap, `stat_o[9:5]` equals `stat_i[9:5]` and `stat_o[16:14]` equals 3'b001. Without a trap, `stat_o[16:14]` equals `stat_i[16:14]`.
- R6: `pc_adv_o` is 1 exactly in the cycle after a non-trapping `valid_i`. `trap_o` and `pc_adv_o` are never 1 together, and each lasts one cycle per `valid_i`.
- R7: An operation with `flags_i` = 0 clears `stat_o[4:0]` and advances the PC.
- R8: The status bits outside fields 27:23, 16:14, 9:5 and 4:0 are copied from `stat_i` into `stat_o` on each `valid_i`.
- R9: A cycle without `valid_i` leaves `stat_o` unchanged and drives both strobes to 0, whatever `flags_i` and `stat_i` are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The operation has completed and `flags_i` is valid |
| flags_i | input | 5 | Raised IEEE exception flags |
| stat_i | input | 32 | Status word current at issue |
| stat_o | output | 32 | Registered, updated status word |
| trap_o | output | 1 | Request for an IEEE exception trap |
| pc_adv_o | output | 1 | Request to advance PC to next-PC, and next-PC by 4 |

## Verification
A wrong priority choice or a wrong trap decision shows up in the cycle right after `valid_i`. It appears as a current field with zero or several bits, or as the wrong one of the two strobes. A bad accrued merge or a bad trap-type write also shows at that same edge, in `stat_o`. The bench compares every bit of that word against a value it builds from `stat_i`, so pass-through corruption is caught as well. A register that updates without `valid_i` is exposed by the idle cycles that follow each update. During those cycles `stat_o` must stay frozen while the inputs are changed.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W   = 5;
  localparam int TEM_LSB  = 23;
  localparam int AEXC_LSB = 5;
  localparam int CEXC_LSB = 0;
  localparam int TT_LSB   = 14;
  localparam int TT_W     = 3;
  localparam int TT_IEEE  = 1;
endpackage

// File: rtl/fpx_trap_dec.sv
module fpx_trap_dec #(
  parameter int FLAG_W = fpx_pkg::FLAG_W
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] tem_i,
  output logic [FLAG_W-1:0] hit_o,
  output logic              trap_o
);
  assign hit_o  = flags_i & tem_i;
  assign trap_o = |hit_o;
endmodule

// File: rtl/fpx_prio_sel.sv
module fpx_prio_sel #(
  parameter int W = fpx_pkg::FLAG_W
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  // highest index wins
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign gnt_o[i] = req_i[i];
    end else begin : g_low
      assign gnt_o[i] = req_i[i] & ~(|req_i[W-1:i+1]);
    end
  end
endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge #(
  parameter int STAT_W   = 32,
  parameter int FLAG_W   = fpx_pkg::FLAG_W,
  parameter int AEXC_LSB = fpx_pkg::AEXC_LSB,
  parameter int CEXC_LSB = fpx_pkg::CEXC_LSB,
  parameter int TT_LSB   = fpx_pkg::TT_LSB,
  parameter int TT_W     = fpx_pkg::TT_W,
  parameter int TT_IEEE  = fpx_pkg::TT_IEEE
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] one_i,
  input  logic              trap_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [TT_W-1:0] TT_VAL = TT_W'(TT_IEEE);

  always_comb begin
    stat_o = stat_i;
    if (trap_i) begin
      stat_o[CEXC_LSB +: FLAG_W] = one_i;
      stat_o[TT_LSB +: TT_W]     = TT_VAL;
    end else begin
      stat_o[CEXC_LSB +: FLAG_W] = flags_i;
      stat_o[AEXC_LSB +: FLAG_W] = stat_i[AEXC_LSB +: FLAG_W] | flags_i;
    end
  end
endmodule

// File: rtl/fpx_status_rec.sv
module fpx_status_rec #(
  parameter int STAT_W  = 32,
  parameter int FLAG_W  = fpx_pkg::FLAG_W,
  parameter int TEM_LSB = fpx_pkg::TEM_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              trap_o,
  output logic              pc_adv_o
);
  logic [FLAG_W-1:0] hit, one;
  logic              trap;
  logic [STAT_W-1:0] stat_nxt, stat_q;
  logic              trap_q, adv_q;

  fpx_trap_dec #(.FLAG_W(FLAG_W)) i_dec (
    .flags_i(flags_i),
    .tem_i  (stat_i[TEM_LSB +: FLAG_W]),
    .hit_o  (hit),
    .trap_o (trap)
  );

  fpx_prio_sel #(.W(FLAG_W)) i_sel (
    .req_i(hit),
    .gnt_o(one)
  );

  fpx_field_merge #(.STAT_W(STAT_W), .FLAG_W(FLAG_W)) i_merge (
    .stat_i (stat_i),
    .flags_i(flags_i),
    .one_i  (one),
    .trap_i (trap),
    .stat_o (stat_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      trap_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      trap_q <= valid_i & trap;
      adv_q  <= valid_i & ~trap;
      if (valid_i) stat_q <= stat_nxt;
    end
  end

  assign stat_o   = stat_q;
  assign trap_o   = trap_q;
  assign pc_adv_o = adv_q;
endmodule

// File: rtl/fpx_status_rec_chk.sv
module fpx_status_rec_chk #(
  parameter int STAT_W   = 32,
  parameter int FLAG_W   = fpx_pkg::FLAG_W,
  parameter int TEM_LSB  = fpx_pkg::TEM_LSB,
  parameter int AEXC_LSB = fpx_pkg::AEXC_LSB,
  parameter int CEXC_LSB = fpx_pkg::CEXC_LSB,
  parameter int TT_LSB   = fpx_pkg::TT_LSB,
  parameter int TT_W     = fpx_pkg::TT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [STAT_W-1:0] stat_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              trap_o,
  input logic              pc_adv_o
);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && pc_adv_o));

  a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (trap_o || pc_adv_o));

  a_r3_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $countones(stat_o[CEXC_LSB +: FLAG_W]) == 1);

  a_r5_trap_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> stat_o[TT_LSB +: TT_W] == TT_W'(1));

  a_r5_no_accrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (trap_o -> stat_o[AEXC_LSB +: FLAG_W] == $past(stat_i[AEXC_LSB +: FLAG_W])));

  a_r4_accrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (pc_adv_o -> stat_o[AEXC_LSB +: FLAG_W] ==
                 ($past(stat_i[AEXC_LSB +: FLAG_W]) | $past(flags_i))));

  a_r2_trap_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (trap_o -> ($past(flags_i) & stat_o[TEM_LSB +: FLAG_W]) != '0));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(stat_o) && !trap_o && !pc_adv_o));
endmodule

bind fpx_status_rec fpx_status_rec_chk #(.STAT_W(STAT_W), .FLAG_W(FLAG_W), .TEM_LSB(TEM_LSB)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .flags_i (flags_i),
  .stat_i  (stat_i),
  .stat_o  (stat_o),
  .trap_o  (trap_o),
  .pc_adv_o(pc_adv_o)
);

// File: tb/test_fpx_status_rec.sv
module test_fpx_status_rec;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hA5A5_A5A5;
  localparam logic [31:0] CLR  = ~(32'h1F << 23) & ~(32'h1F << 5);
  localparam int NV = 12;
  // {tem, aexc_in, flags, exp_cexc, exp_aexc, exp_trap}
  localparam logic [25:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b0}, // R7 zero flags
    {5'b00000, 5'b00011, 5'b10001, 5'b10001, 5'b10011, 1'b0}, // R4
    {5'b10000, 5'b00000, 5'b10000, 5'b10000, 5'b00000, 1'b1}, // R2 invalid
    {5'b11111, 5'b00101, 5'b11111, 5'b10000, 5'b00101, 1'b1}, // R3 all
    {5'b01111, 5'b00000, 5'b11111, 5'b01000, 5'b00000, 1'b1}, // R3 overflow
    {5'b00111, 5'b01010, 5'b00110, 5'b00100, 5'b01010, 1'b1}, // R3 underflow
    {5'b00011, 5'b00000, 5'b00011, 5'b00010, 5'b00000, 1'b1}, // R3 div0
    {5'b00001, 5'b00000, 5'b00001, 5'b00001, 5'b00000, 1'b1}, // R3 inexact
    {5'b11100, 5'b00001, 5'b00011, 5'b00011, 5'b00011, 1'b0}, // R2 not enabled
    {5'b01010, 5'b11111, 5'b00101, 5'b00101, 5'b11111, 1'b0}, // R4
    {5'b00110, 5'b00000, 5'b11011, 5'b00010, 5'b00000, 1'b1}, // R3 masked
    {5'b10001, 5'b10000, 5'b00000, 5'b00000, 5'b10000, 1'b0}  // R7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  flags_i = '0;
  logic [31:0] stat_i = '0;
  logic [31:0] stat_o;
  logic        trap_o, pc_adv_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpx_status_rec i_fpx_status_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .flags_i(flags_i),
    .stat_i(stat_i), .stat_o(stat_o), .trap_o(trap_o), .pc_adv_o(pc_adv_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset stat_o", stat_o, 32'h0);
    chk("R1 reset trap_o", 32'(trap_o), 32'h0);
    chk("R1 reset pc_adv_o", 32'(pc_adv_o), 32'h0);
    rst_ni = 1'b1;
    last = '0;

    for (int k = 0; k < NV; k++) begin
      logic [4:0] tem, ae, fl, ec, ea;
      logic       et;
      logic [31:0] s, e;
      {tem, ae, fl, ec, ea, et} = VEC[k];
      s = (BASE & CLR) | (32'(tem) << 23) | (32'(ae) << 5);
      e = s;
      e[4:0] = ec;
      e[9:5] = ea;
      if (et) e[16:14] = 3'b001;
      @(negedge clk_i);
      stat_i = s; flags_i = fl; valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      chk($sformatf("R3 R4 R5 R8 stat_o vec %0d", k), stat_o, e);
      chk($sformatf("R2 trap_o vec %0d", k), 32'(trap_o), 32'(et));
      chk($sformatf("R6 R7 pc_adv_o vec %0d", k), 32'(pc_adv_o), 32'(!et));
      last = e;
    end

    // idle cycles with moving inputs
    for (int j = 0; j < 3; j++) begin
      stat_i = 32'hFFFF_FFFF ^ (32'(j) << 3);
      flags_i = 5'b11111;
      @(negedge clk_i);
      chk("R9 idle stat_o", stat_o, last);
      chk("R6 R9 idle trap_o", 32'(trap_o), 32'h0);
      chk("R6 R9 idle pc_adv_o", 32'(pc_adv_o), 32'h0);
    end

    // back-to-back: trap then non-trap
    stat_i = 32'h0080_0000; flags_i = 5'b00001; valid_i = 1'b1; // inexact enabled
    @(negedge clk_i);
    chk("R5 b2b stat_o trap", stat_o, 32'h0080_4001);
    chk("R2 b2b trap_o", 32'(trap_o), 32'h1);
    stat_i = 32'h0000_4000; flags_i = 5'b00100;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R4 R5 b2b stat_o keep type", stat_o, 32'h0000_4084);
    chk("R6 b2b pc_adv_o", 32'(pc_adv_o), 32'h1);
    chk("R6 b2b trap_o", 32'(trap_o), 32'h0);

    // asynchronous reset in mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async stat_o", stat_o, 32'h0);
    chk("R1 async pc_adv_o", 32'(pc_adv_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule